// File: doc/BRIEF.md
# Branch Outcome Map Accumulator

This block sits in the front end of an instruction trace encoder and gathers the outcomes of retired branches into a compact bit vector. Each cycle it sees at most one retired instruction: a qualification flag, an instruction-type code and a not-taken indication. Branch outcomes are packed into the vector in retirement order, and the pending entry count is kept beside it.

When the surrounding encoder decides to emit a packet, it raises a flush request. The block then presents, for one cycle, the accumulated vector, how many entries it holds, and a format bit. The format bit tells the packet builder to use either the branch-carrying layout, when at least one entry is pending, or the address-only layout, when none is. The map is cleared in the same step. The encoder must flush before any synchronization packet, because that packet carries no branch history. The vector is bounded. A branch that arrives while it is full forces an emission of the full map on its own, and the new outcome starts a fresh map.

Top module: `branch_map_acc`

## Requirements
- R1: An instruction counts as a branch only when `i_qual` is 1 and either `i_itype` equals 4 or 5 or `i_ntkn` is non-zero. Every other type code with `i_ntkn` zero records nothing.
- R2: The recorded bit is 1 (not taken) when `i_ntkn` is non-zero or `i_itype` is 4. It is 0 (taken) when `i_itype` is 5 and `i_ntkn` is zero.
- R3: Each recorded outcome goes to bit position equal to the pending count before it, starting at bit 0. The pending count `o_pend_cnt` rises by exactly one in the cycle after the branch.
- R4: With `i_qual` low and no flush, the pending count and the map contents are left unchanged, whatever the type code and not-taken inputs are.
- R5: `o_full` is 1 exactly when the pending count equals the map depth (31 by default).
- R6: A flush request makes `o_emit_valid` 1 in the following cycle. In that cycle `o_emit_map` and `o_emit_cnt` hold the map and count as they were before the flush, and the pending state is cleared. In any other cycle `o_emit_valid`, `o_emit_map`, `o_emit_cnt` and `o_emit_fmt` are all 0.
- R7: During an emission `o_emit_fmt` is 1 (branch format) when the emitted count is non-zero, and 0 (address-only format) when it is zero.
- R8: A flush and a branch in the same cycle emit the old map, and the new outcome lands in bit 0 of the fresh map with a pending count of 1.
- R9: A branch arriving while `o_full` is 1 forces an emission of all depth entries without a flush request. The new outcome lands in bit 0 with a pending count of 1.
- R10: Reset clears the map and count, drops `o_full`, and suppresses any emission.
- R11: The pending count never exceeds the map depth, and map bits at or above the pending count are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_qual | input | 1 | Retired instruction is valid and passes the trace filter |
| i_itype | input | TYPE_W | Instruction-type code |
| i_ntkn | input | NTKN_W | Not-taken indication, non-zero means not taken |
| i_flush | input | 1 | Request to emit and clear the map |
| o_full | output | 1 | Map holds its maximum number of entries |
| o_pend_cnt | output | CNT_W | Number of unreported outcomes |
| o_emit_valid | output | 1 | Emission pulse |
| o_emit_map | output | MAP_DEPTH | Emitted outcome vector |
| o_emit_cnt | output | CNT_W | Number of valid bits in the emitted vector |
| o_emit_fmt | output | 1 | 1 selects the branch format, 0 the address-only format |

## Verification
A wrong bit position or outcome polarity is not visible while entries accumulate. It appears in `o_emit_map` in the cycle after the next flush, so every sweep ends each pattern with a flush and compares the whole vector. A count that drifts shows up at once on `o_pend_cnt` and `o_full`. It also shows up one cycle after a flush on `o_emit_cnt` and `o_emit_fmt`. A missed overflow shows up as a missing emission in the cycle after the 32nd branch.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
    // Instruction-type codes that mark a conditional branch
    localparam int unsigned BR_CODE_NTKN = 4;  // reported as not taken
    localparam int unsigned BR_CODE_TKN  = 5;  // reported as taken

    // Packet layout selector driven by the emitted count
    typedef enum logic {
        FMT_ADDR_ONLY = 1'b0,
        FMT_BRANCH    = 1'b1
    } pkt_fmt_e;
endpackage

// File: rtl/bmap_classify.sv
module bmap_classify
    import bmap_pkg::*;
#(
    parameter int unsigned TYPE_W = 4,
    parameter int unsigned NTKN_W = 2
) (
    input  logic              qual,
    input  logic [TYPE_W-1:0] itype,
    input  logic [NTKN_W-1:0] ntkn,
    output logic              is_br,
    output logic              outcome
);
    localparam logic [TYPE_W-1:0] CODE_NT = TYPE_W'(BR_CODE_NTKN);
    localparam logic [TYPE_W-1:0] CODE_TK = TYPE_W'(BR_CODE_TKN);

    logic type_hit;
    logic ntkn_hit;

    always_comb begin
        type_hit = (itype == CODE_NT) || (itype == CODE_TK);
        ntkn_hit = |ntkn;
        is_br    = qual && (type_hit || ntkn_hit);
        outcome  = ntkn_hit || (itype == CODE_NT);
    end
endmodule

// File: rtl/bmap_emit.sv
module bmap_emit
    import bmap_pkg::*;
#(
    parameter int unsigned MAP_DEPTH = 31,
    parameter int unsigned CNT_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [MAP_DEPTH-1:0] map_in,
    input  logic [CNT_W-1:0]     cnt_in,
    output logic                 emit_valid,
    output logic [MAP_DEPTH-1:0] emit_map,
    output logic [CNT_W-1:0]     emit_cnt,
    output logic                 emit_fmt
);
    typedef struct packed {
        logic                 valid;
        logic [MAP_DEPTH-1:0] map;
        logic [CNT_W-1:0]     cnt;
        pkt_fmt_e             fmt;
    } emit_t;

    emit_t emit_d, emit_q;

    always_comb begin
        emit_d = '0;
        if (fire) begin
            emit_d.valid = 1'b1;
            emit_d.map   = map_in;
            emit_d.cnt   = cnt_in;
            emit_d.fmt   = (cnt_in != '0) ? FMT_BRANCH : FMT_ADDR_ONLY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) emit_q <= '0;
        else        emit_q <= emit_d;
    end

    assign emit_valid = emit_q.valid;
    assign emit_map   = emit_q.map;
    assign emit_cnt   = emit_q.cnt;
    assign emit_fmt   = emit_q.fmt;

    a_r7_fmt_matches_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |-> (emit_fmt == (emit_cnt != '0)));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_valid |-> (emit_map == '0 && emit_cnt == '0 && !emit_fmt));
endmodule

// File: rtl/branch_map_acc.sv
module branch_map_acc
    import bmap_pkg::*;
#(
    parameter  int unsigned MAP_DEPTH = 31,
    parameter  int unsigned TYPE_W    = 4,
    parameter  int unsigned NTKN_W    = 2,
    localparam int unsigned CNT_W     = $clog2(MAP_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_qual,
    input  logic [TYPE_W-1:0]    i_itype,
    input  logic [NTKN_W-1:0]    i_ntkn,
    input  logic                 i_flush,
    output logic                 o_full,
    output logic [CNT_W-1:0]     o_pend_cnt,
    output logic                 o_emit_valid,
    output logic [MAP_DEPTH-1:0] o_emit_map,
    output logic [CNT_W-1:0]     o_emit_cnt,
    output logic                 o_emit_fmt
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAP_DEPTH);

    typedef struct packed {
        logic [MAP_DEPTH-1:0] map;
        logic [CNT_W-1:0]     cnt;
    } acc_t;

    acc_t acc_d, acc_q;
    logic is_br;
    logic outcome;
    logic full_q;
    logic take_flush;

    bmap_classify #(
        .TYPE_W (TYPE_W),
        .NTKN_W (NTKN_W)
    ) u_classify (
        .qual    (i_qual),
        .itype   (i_itype),
        .ntkn    (i_ntkn),
        .is_br   (is_br),
        .outcome (outcome)
    );

    always_comb begin
        full_q     = (acc_q.cnt == FULL_CNT);
        take_flush = i_flush || (is_br && full_q);
        acc_d      = acc_q;
        if (take_flush) begin
            acc_d.map = '0;
            acc_d.cnt = '0;
            if (is_br) begin
                acc_d.map[0] = outcome;
                acc_d.cnt    = CNT_W'(1);
            end
        end else if (is_br) begin
            acc_d.map[acc_q.cnt] = outcome;
            acc_d.cnt            = acc_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    bmap_emit #(
        .MAP_DEPTH (MAP_DEPTH),
        .CNT_W     (CNT_W)
    ) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (take_flush),
        .map_in     (acc_q.map),
        .cnt_in     (acc_q.cnt),
        .emit_valid (o_emit_valid),
        .emit_map   (o_emit_map),
        .emit_cnt   (o_emit_cnt),
        .emit_fmt   (o_emit_fmt)
    );

    assign o_full     = full_q;
    assign o_pend_cnt = acc_q.cnt;

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && !take_flush) |=> (acc_q.cnt == $past(acc_q.cnt) + CNT_W'(1)));

    a_r4_unqualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_qual && !i_flush) |=> (acc_q == $past(acc_q)));

    a_r9_forced_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (o_full && is_br) |=> (o_emit_valid && o_emit_cnt == FULL_CNT && acc_q.cnt == CNT_W'(1)));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.cnt <= FULL_CNT) && ((acc_q.map >> acc_q.cnt) == '0));

    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (i_flush && !is_br) |=> (acc_q.cnt == '0 && o_emit_valid));
endmodule

// File: tb/branch_map_acc_tb.sv
module branch_map_acc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 31;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       i_qual;
    logic [3:0] i_itype;
    logic [1:0] i_ntkn;
    logic       i_flush;
    logic       o_full;
    logic [4:0] o_pend_cnt;
    logic       o_emit_valid;
    logic [30:0] o_emit_map;
    logic [4:0] o_emit_cnt;
    logic       o_emit_fmt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [30:0] m_map;
    int          m_cnt;
    logic        x_valid;
    logic [30:0] x_map;
    int          x_cnt;
    logic        x_fmt;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_map_acc u_dut (
        .clk(clk), .rst_n(rst_n), .i_qual(i_qual), .i_itype(i_itype),
        .i_ntkn(i_ntkn), .i_flush(i_flush), .o_full(o_full),
        .o_pend_cnt(o_pend_cnt), .o_emit_valid(o_emit_valid),
        .o_emit_map(o_emit_map), .o_emit_cnt(o_emit_cnt), .o_emit_fmt(o_emit_fmt)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input string etag);
        chk(etag, "emit_valid", o_emit_valid, x_valid);
        chk(tag,  "emit_map",   o_emit_map,   x_map);
        chk(etag, "emit_cnt",   o_emit_cnt,   x_cnt);
        chk("R7", "emit_fmt",   o_emit_fmt,   x_fmt);
        chk(tag,  "pend_cnt",   o_pend_cnt,   m_cnt);
        chk("R5", "full",       o_full,       (m_cnt == DEPTH));
    endtask

    // One instruction slot; the expected state comes from the requirement text.
    task automatic step(input bit v, input int t, input int n, input bit f,
                        input string tag, input string etag);
        bit br, ob, fl;
        br = v && (t == 4 || t == 5 || n != 0);
        ob = (n != 0) || (t == 4);
        fl = f || (br && m_cnt == DEPTH);
        i_qual = v; i_itype = 4'(t); i_ntkn = 2'(n); i_flush = f;
        x_valid = 0; x_map = '0; x_cnt = 0; x_fmt = 0;
        if (fl) begin
            x_valid = 1; x_map = m_map; x_cnt = m_cnt; x_fmt = (m_cnt != 0);
            m_map = '0; m_cnt = 0;
            if (br) begin m_map[0] = ob; m_cnt = 1; end
        end else if (br) begin
            m_map[m_cnt] = ob; m_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        check_all(tag, etag);
    endtask

    task automatic do_reset();
        rst_n = 0; i_qual = 0; i_itype = 0; i_ntkn = 0; i_flush = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_map = '0; m_cnt = 0;
        x_valid = 0; x_map = '0; x_cnt = 0; x_fmt = 0;
        check_all("R10", "R10");
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1, R2, R4: every type code, not-taken value and qualifier, each followed by a flush
        for (int v = 0; v < 2; v++)
            for (int t = 0; t < 16; t++)
                for (int n = 0; n < 4; n++) begin
                    step(v[0], t, n, 1'b0, (v == 0) ? "R4" : "R1", "R1");
                    step(1'b0, t, n, 1'b1, "R2", "R6");
                end

        // R3, R7, R11: fill to every length with a mixed pattern, then flush
        for (int len = 0; len <= DEPTH; len++) begin
            for (int k = 0; k < len; k++)
                step(1'b1, (((k * 7 + len) % 3) == 0) ? 4 : 5, 0, 1'b0, "R3", "R3");
            step(1'b0, 0, 0, 1'b1, "R11", "R6");
        end

        // R4 with a partly filled map: unqualified branches between qualified ones
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 5, k % 2, 1'b0, "R3", "R3");
            step(1'b0, 4, 3, 1'b0, "R4", "R4");
        end
        step(1'b0, 0, 0, 1'b1, "R4", "R6");

        // R9: overflow forces emission, new outcome starts the next map
        for (int k = 0; k < DEPTH; k++) step(1'b1, 5, 0, 1'b0, "R5", "R5");
        step(1'b1, 4, 0, 1'b0, "R9", "R9");
        step(1'b1, 5, 0, 1'b0, "R9", "R9");
        step(1'b0, 0, 0, 1'b1, "R9", "R6");

        // R8: flush together with a branch
        for (int k = 0; k < 3; k++) step(1'b1, 4, 0, 1'b0, "R3", "R3");
        step(1'b1, 0, 2, 1'b1, "R8", "R8");
        step(1'b1, 1, 0, 1'b1, "R8", "R8");
        step(1'b0, 0, 0, 1'b1, "R8", "R6");
        step(1'b0, 0, 0, 1'b1, "R7", "R6");

        // R10: reset in the middle of a partly filled map
        for (int k = 0; k < 5; k++) step(1'b1, 4, 0, 1'b0, "R3", "R3");
        do_reset();
        step(1'b0, 0, 0, 1'b1, "R10", "R6");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule